// File: doc/BRIEF.md
# Four-Channel Shadow-Loaded Pulse Generator

This block produces four independent pulse-width-modulated outputs from one clock. Each channel is configured through a plain 32-bit register port with valid, write, address and data signals. A channel is described by a period length in clock cycles and a tail length. The tail length is the number of cycles in each period that the output spends at its inactive level. Software chooses per channel whether the active level is high or low, and whether the channel's pad is driven.

Configuration values never reach a running channel directly. A channel copies its period and tail registers into private working copies when its start bit goes from 0 to 1. After that, a running channel takes new values only when software writes its update bit to 1 and then back to 0. The new values are staged on the clock after the falling write. They replace the working copies at the next period boundary, so no shortened pulse appears on the pad.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every period register reads 2 and every tail register reads 1. The polarity, start, update and pad-enable registers read 0, and all outputs are low.
- R2: Register map, read data valid one cycle after the read request. Channel n's tail register is at 0x00+8n and its period register at 0x04+8n. Shared registers hold bit n for channel n: polarity at 0x40, start at 0x44, done at 0x48 (read-only), update at 0x4C and pad enable at 0xD0.
- R3: A channel whose start bit is 0 drives its output low.
- R4: With polarity bit 0, each period of P cycles is high for its first P−L cycles and low for its last L cycles, where L is the tail length. The first high cycle appears on the output two cycles after the cycle in which the start bit reads 1.
- R5: With polarity bit 1, the output is inverted, so it is high for L cycles in each period.
- R6: A tail length of 0 gives a constant active output, which is constant high with polarity 0.
- R7: A tail length larger than the period is treated as equal to the period, so the output stays inactive. A period below 2 is treated as 2.
- R8: A 0-to-1 edge of the start bit loads the working copies. Writes to the period or tail registers of a running channel have no effect on its output until an update toggle.
- R9: After the update bit of a running channel is written 1 and then 0, the new period and tail values take effect at the next period boundary.
- R10: Each bit of the pad-enable output follows its pad-enable register bit.
- R11: A done bit reads 1 exactly when that channel's start bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | Pulse outputs, one per channel |
| pad_oe | output | 4 | Pad drive enable, one per channel |

## Verification
On every cycle, the assertions check that a stopped channel's output is low and that a running channel's counter stays below its working period. They also check that the working tail never exceeds the working period, that the working period never drops below 2, and that the working copies change only on a start edge or at a period boundary. The bench's scenarios are needed to show several other points: the exact high and low pattern and its alignment after start, the polarity inversion, the clamping, and that staged values stay hidden until an update toggle. Register readback, the reset contents and the done and pad-enable bits are also covered only by the bench.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [7:0] OFS_POL   = 8'h40;
  localparam logic [7:0] OFS_START = 8'h44;
  localparam logic [7:0] OFS_DONE  = 8'h48;
  localparam logic [7:0] OFS_UPD   = 8'h4C;
  localparam logic [7:0] OFS_OE    = 8'hD0;
  localparam int unsigned RST_PERIOD = 2;
  localparam int unsigned RST_TAIL   = 1;
  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_CH-1:0][CNT_W-1:0]  period_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  tail_o,
  output logic [NUM_CH-1:0]             pol_o,
  output logic [NUM_CH-1:0]             start_o,
  output logic [NUM_CH-1:0]             upd_o,
  output logic [NUM_CH-1:0]             oe_o
);
  import pwm_pkg::*;

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][CNT_W-1:0] period_q, tail_q;
  logic [NUM_CH-1:0] pol_q, start_q, upd_q, oe_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic        in_chan_space;
  logic [CH_W-1:0] sel_ch;
  logic        sel_period;
  logic        wr_en;

  always_comb begin
    in_chan_space = (bus_addr < ADDR_W'(8 * NUM_CH)) && (bus_addr[1:0] == 2'b00);
    sel_ch        = bus_addr[CH_W+2:3];
    sel_period    = bus_addr[2];
    wr_en         = bus_valid && bus_write;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        period_q[i] <= CNT_W'(RST_PERIOD);
        tail_q[i]   <= CNT_W'(RST_TAIL);
      end
      pol_q   <= '0;
      start_q <= '0;
      upd_q   <= '0;
      oe_q    <= '0;
    end else if (wr_en) begin
      if (in_chan_space) begin
        if (sel_period) period_q[sel_ch] <= bus_wdata[CNT_W-1:0];
        else            tail_q[sel_ch]   <= bus_wdata[CNT_W-1:0];
      end
      case (bus_addr)
        OFS_POL:   pol_q   <= bus_wdata[NUM_CH-1:0];
        OFS_START: start_q <= bus_wdata[NUM_CH-1:0];
        OFS_UPD:   upd_q   <= bus_wdata[NUM_CH-1:0];
        OFS_OE:    oe_q    <= bus_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_chan_space) begin
      rd_mux[CNT_W-1:0] = sel_period ? period_q[sel_ch] : tail_q[sel_ch];
    end else begin
      case (bus_addr)
        OFS_POL:   rd_mux[NUM_CH-1:0] = pol_q;
        OFS_START: rd_mux[NUM_CH-1:0] = start_q;
        OFS_DONE:  rd_mux[NUM_CH-1:0] = ~start_q;
        OFS_UPD:   rd_mux[NUM_CH-1:0] = upd_q;
        OFS_OE:    rd_mux[NUM_CH-1:0] = oe_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          rdata_q <= '0;
    else if (bus_valid && !bus_write) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign period_o  = period_q;
  assign tail_o    = tail_q;
  assign pol_o     = pol_q;
  assign start_o   = start_q;
  assign upd_o     = upd_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             upd_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [CNT_W-1:0] cfg_tail_i,
  output logic             out_o
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_period_q, act_tail_q;
  logic [CNT_W-1:0] pend_period_q, pend_tail_q;
  logic             pend_valid_q;
  logic             run_q, upd_d_q, out_q;

  logic [CNT_W-1:0] lim_period, lim_tail, hi_len;
  logic             start_rise, upd_fall, at_end, in_active;

  always_comb begin
    lim_period = (cfg_period_i < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : cfg_period_i;
    lim_tail   = (cfg_tail_i > lim_period) ? lim_period : cfg_tail_i;
    start_rise = start_i && !run_q;
    upd_fall   = !upd_i && upd_d_q;
    at_end     = (cnt_q == act_period_q - CNT_W'(1));
    hi_len     = act_period_q - act_tail_q;
    in_active  = (cnt_q < hi_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      act_period_q  <= CNT_W'(RST_PERIOD);
      act_tail_q    <= CNT_W'(RST_TAIL);
      pend_period_q <= CNT_W'(RST_PERIOD);
      pend_tail_q   <= CNT_W'(RST_TAIL);
      pend_valid_q  <= 1'b0;
      run_q         <= 1'b0;
      upd_d_q       <= 1'b0;
      out_q         <= 1'b0;
    end else begin
      run_q   <= start_i;
      upd_d_q <= upd_i;
      out_q   <= run_q && (in_active ^ pol_i);
      if (!start_i) begin
        cnt_q        <= '0;
        pend_valid_q <= 1'b0;
      end else if (start_rise) begin
        cnt_q        <= '0;
        act_period_q <= lim_period;
        act_tail_q   <= lim_tail;
        pend_valid_q <= 1'b0;
      end else begin
        cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        if (at_end && pend_valid_q) begin
          act_period_q <= pend_period_q;
          act_tail_q   <= pend_tail_q;
          pend_valid_q <= 1'b0;
        end
        if (upd_fall) begin
          pend_period_q <= lim_period;
          pend_tail_q   <= lim_tail;
          pend_valid_q  <= 1'b1;
        end
      end
    end
  end

  assign out_o = out_q;

  // R3
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !out_q);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < act_period_q));

  // R7
  tail_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (act_tail_q <= act_period_q) && (act_period_q >= CNT_W'(MIN_PERIOD)));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_rise && !at_end) |=> ($stable(act_period_q) && $stable(act_tail_q)));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pad_oe
);
  logic [NUM_CH-1:0][CNT_W-1:0] period_w, tail_w;
  logic [NUM_CH-1:0] pol_w, start_w, upd_w, oe_w;

  pwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .period_o(period_w), .tail_o(tail_w), .pol_o(pol_w),
    .start_o(start_w), .upd_o(upd_w), .oe_o(oe_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst),
      .start_i(start_w[g]), .upd_i(upd_w[g]), .pol_i(pol_w[g]),
      .cfg_period_i(period_w[g]), .cfg_tail_i(tail_w[g]),
      .out_o(pwm_out[g])
    );
  end

  assign pad_oe = oe_w;
endmodule

// File: tb/sim_pwm_quad.sv
module sim_pwm_quad;
  logic clk = 0;
  logic rst = 1;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0] pwm_out, pad_oe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pwm_quad u0 (.clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
               .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
               .pwm_out(pwm_out), .pad_oe(pad_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 outputs", {28'd0, pwm_out}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(8'(8*c + 4), d); chk("R1 period", d, 32'd2);
      rd(8'(8*c), d);     chk("R1 tail", d, 32'd1);
    end
    rd(8'h40, d); chk("R1 pol", d, 0);
    rd(8'h44, d); chk("R1 start", d, 0);
    rd(8'h4C, d); chk("R1 upd", d, 0);
    rd(8'hD0, d); chk("R1 oe", d, 0);
    chk("R1 pad_oe", {28'd0, pad_oe}, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(8'h10, 32'h123);
    rd(8'h10, d); chk("R2 tail ch2", d, 32'h123);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R2 period ch2 width", d, 32'h3FFF_FFFF);
  endtask

  task automatic t_basic;
    int hi;
    wr(8'h04, 10); wr(8'h00, 3);
    wr(8'h44, 32'h1);
    chk("R4 pre", {31'd0, pwm_out[0]}, 0);
    @(negedge clk);
    chk("R4 pre2", {31'd0, pwm_out[0]}, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R4 pattern", {31'd0, pwm_out[0]}, (i < 7) ? 1 : 0);
    end
    count_hi(0, 10, hi); chk("R4 high count", hi, 7);
  endtask

  task automatic t_shadow;
    int hi;
    wr(8'h04, 6); wr(8'h00, 1);
    idle(25);
    count_hi(0, 10, hi); chk("R8 no effect before update", hi, 7);
    count_hi(0, 10, hi); chk("R8 no effect before update 2", hi, 7);
    wr(8'h4C, 32'h1); wr(8'h4C, 32'h0);
    idle(25);
    count_hi(0, 6, hi); chk("R9 new values", hi, 5);
    count_hi(0, 6, hi); chk("R9 new values 2", hi, 5);
  endtask

  task automatic t_pol;
    int hi;
    wr(8'h0C, 8); wr(8'h08, 3);
    wr(8'h40, 32'h2);
    wr(8'h44, 32'h3);
    idle(6);
    count_hi(1, 8, hi); chk("R5 inverted", hi, 3);
    count_hi(1, 16, hi); chk("R5 inverted 2", hi, 6);
  endtask

  task automatic t_full;
    int hi;
    wr(8'h14, 5); wr(8'h10, 0);
    wr(8'h44, 32'h7);
    idle(4);
    count_hi(2, 15, hi); chk("R6 constant high", hi, 15);
  endtask

  task automatic t_clamp;
    int hi;
    wr(8'h1C, 4); wr(8'h18, 9);
    wr(8'h44, 32'hF);
    idle(4);
    count_hi(3, 12, hi); chk("R7 tail clamp", hi, 0);
    wr(8'h44, 32'h7);
    idle(3);
    count_hi(3, 8, hi); chk("R3 stopped low", hi, 0);
    wr(8'h1C, 0); wr(8'h18, 1);
    wr(8'h44, 32'hF);
    idle(4);
    count_hi(3, 8, hi); chk("R7 period min", hi, 4);
  endtask

  task automatic t_done_oe;
    logic [31:0] d;
    wr(8'h44, 32'h3);
    rd(8'h48, d); chk("R11 done", d, 32'hC);
    wr(8'h48, 32'hF);
    rd(8'h48, d); chk("R11 done read-only", d, 32'hC);
    wr(8'hD0, 32'h5);
    chk("R10 pad_oe", {28'd0, pad_oe}, 32'h5);
    rd(8'hD0, d); chk("R10 oe readback", d, 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_readback();
    t_basic();
    t_shadow();
    t_pol();
    t_full();
    t_clamp();
    t_done_oe();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule